// File: doc/BRIEF.md
# Boundary-scan BIST sequencer

This block wraps a combinational core with a ring of input boundary cells and output boundary cells that form one serial scan path, and uses that ring as its own self-test engine. The lowest cells of the input ring form a linear-feedback pattern source. Its serial output is fed into the rest of the path. The highest cells of the output ring form a signature compactor. The compactor takes the core's outputs in parallel on a capture cycle and takes the bit stream leaving the path serially while patterns are shifted in.

A one-cycle `start` pulse begins a run. The controller first seeds the source and the compactor. It then fills the path with pseudorandom bits and captures the core's response, and repeats this for a fixed number of patterns. One more shift flushes the last response into the compactor. The final signature is then compared with a golden parameter, and the `done` and `pass` flags are raised. Outside a run the ring is transparent: pin inputs reach the core and core outputs reach the pins unchanged.

Parameters: `N_IN` and `N_OUT` set the ring sizes, `R` (2 ≤ R < N_IN) sets the source width and `S` (2 ≤ S < N_OUT) sets the compactor width. `NUM_PAT` sets the pattern count. The two feedback polynomials, the two seeds and `GOLDEN` are also parameters. The path order runs from input cell 0 up to input cell N_IN-1, then from output cell 0 up to output cell N_OUT-1, so the path length is L = N_IN + N_OUT.

Top module: `bscan_bist`

## Requirements
- R1: While no run is in progress, `core_in` equals `sys_in` and `sys_out` equals `core_out` in the same cycle.
- R2: A `start` pulse seen in the idle state begins a run from the next cycle. While a run is in progress, `test_active` is 1, `core_in` carries the N_IN input cells and `sys_out` carries the N_OUT output cells.
- R3: The seed cycle (the first cycle of a run) loads the source with `PRPG_SEED` and the compactor with `SIG_SEED`, and clears every other cell to 0.
- R4: A shift cycle does three things. The source steps as a Fibonacci register: bits move up by one, and the new bit 0 is the XOR of the source bits selected by `PRPG_POLY`. The old top source bit enters the next path cell, and every middle cell takes the value of the cell below it. The compactor steps as a Galois register: it shifts up, is XORed with `SIG_POLY` when its old top bit was 1, and has the cell just below it XORed into bit 0.
- R5: A capture cycle does four things. Input cells R..N_IN-1 load `sys_in`. Output cells 0..N_OUT-S-1 load `core_out`. The compactor takes the Galois step of R4 with `core_out[N_OUT-1:N_OUT-S]` XORed in. The source holds its value.
- R6: A run has exactly 1 seed cycle, then NUM_PAT pairs of (L-S shift cycles, 1 capture cycle), then L-S flush shift cycles, then 1 compare cycle, so `test_active` stays high for 2 + (NUM_PAT+1)(L-S) + NUM_PAT cycles.
- R7: The compare cycle ends the run. From the next cycle `done` is 1 and `pass` is 1 exactly when the compactor equals `GOLDEN`. Both flags hold until the next accepted `start`, which clears them.
- R8: A `start` pulse during a run is ignored: neither the run's length nor its signature changes.
- R9: While `rst_n` is low, `done`, `pass` and `test_active` are 0 and the ring is transparent. After `rst_n` rises, a `start` is accepted only from the third rising clock edge onward.
- R10: With `PRPG_POLY` bit R-1 set and a nonzero seed, the source never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start | input | 1 | One-cycle request to begin a self-test run |
| sys_in | input | N_IN | Values from the input pins |
| core_in | output | N_IN | Values driven into the core |
| core_out | input | N_OUT | Values produced by the core |
| sys_out | output | N_OUT | Values driven to the output pins |
| test_active | output | 1 | High while a run is in progress |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Final signature matched GOLDEN; valid while done |

## Verification
The assertions assume three things. The source polynomial has its top tap set and its seed is nonzero, so the all-zero state cannot be reached. `start` is sampled only on clock edges after the synchronised reset. `core_out` is a pure function of `core_in` within the cycle. The bench keeps to these assumptions: its core is a combinational function of `core_in`, and its parameters satisfy the polynomial and seed conditions. It holds `sys_in` at one value throughout each run, so the golden signature it computes for the fault-free core is fixed before the run starts. A selectable fault in the bench core is then expected to turn `pass` low.

// File: rtl/bscan_bist_pkg.sv
package bscan_bist_pkg;

  // Controller phases of a self-test run.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEED  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_CAPT  = 3'd3,
    ST_CMP   = 3'd4
  } bist_state_e;

  // Operation applied to the boundary cells in the current cycle.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SEED  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_CAPT  = 2'd3
  } cell_op_e;

endpackage

// File: rtl/bscan_bist_rst_sync.sv
module bscan_bist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/bscan_bist_ctrl.sv
module bscan_bist_ctrl
  import bscan_bist_pkg::*;
#(
  parameter int SHIFT_LEN = 12,
  parameter int NUM_PAT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sig_match,
  output bist_state_e state,
  output cell_op_e    op,
  output logic        test_active,
  output logic        done,
  output logic        pass
);

  localparam int CNT_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;
  localparam int PAT_W = $clog2(NUM_PAT + 1);

  bist_state_e      state_q, state_d;
  logic [CNT_W-1:0] shcnt_q, shcnt_d;
  logic [PAT_W-1:0] patcnt_q, patcnt_d;
  logic             done_q, done_d, pass_q, pass_d;
  logic             sh_en, pat_en, flag_en;
  logic             sh_last, pat_last;

  assign sh_last  = (shcnt_q == CNT_W'(SHIFT_LEN - 1));
  assign pat_last = (patcnt_q == PAT_W'(NUM_PAT));

  // Next-state and enables.
  always_comb begin
    state_d  = state_q;
    shcnt_d  = shcnt_q;
    patcnt_d = patcnt_q;
    done_d   = done_q;
    pass_d   = pass_q;
    sh_en    = 1'b0;
    pat_en   = 1'b0;
    flag_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SEED;
          flag_en = 1'b1;
          done_d  = 1'b0;
          pass_d  = 1'b0;
        end
      end
      ST_SEED: begin
        state_d  = ST_SHIFT;
        sh_en    = 1'b1;
        shcnt_d  = '0;
        pat_en   = 1'b1;
        patcnt_d = '0;
      end
      ST_SHIFT: begin
        sh_en = 1'b1;
        if (sh_last) begin
          shcnt_d = '0;
          state_d = pat_last ? ST_CMP : ST_CAPT;
        end else begin
          shcnt_d = shcnt_q + CNT_W'(1);
        end
      end
      ST_CAPT: begin
        pat_en   = 1'b1;
        patcnt_d = patcnt_q + PAT_W'(1);
        state_d  = ST_SHIFT;
      end
      ST_CMP: begin
        state_d = ST_IDLE;
        flag_en = 1'b1;
        done_d  = 1'b1;
        pass_d  = sig_match;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shcnt_q <= '0;
    end else if (sh_en) begin
      shcnt_q <= shcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      patcnt_q <= '0;
    end else if (pat_en) begin
      patcnt_q <= patcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  // Cell operation decode.
  always_comb begin
    unique case (state_q)
      ST_SEED:  op = OP_SEED;
      ST_SHIFT: op = OP_SHIFT;
      ST_CAPT:  op = OP_CAPT;
      default:  op = OP_HOLD;
    endcase
  end

  assign state       = state_q;
  assign test_active = (state_q != ST_IDLE);
  assign done        = done_q;
  assign pass        = pass_q;

endmodule

// File: rtl/bscan_bist_prpg.sv
module bscan_bist_prpg
  import bscan_bist_pkg::*;
#(
  parameter int           W    = 4,
  parameter logic [W-1:0] POLY = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cell_op_e     op,
  output logic [W-1:0] q,
  output logic         ser_out
);

  logic [W-1:0] q_q, q_d;
  logic         fb;
  logic         en;

  assign fb = ^(q_q & POLY);
  assign en = (op == OP_SEED) || (op == OP_SHIFT);

  always_comb begin
    unique case (op)
      OP_SEED:  q_d = SEED;
      OP_SHIFT: q_d = {q_q[W-2:0], fb};
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= SEED;
    end else if (en) begin
      q_q <= q_d;
    end
  end

  assign q       = q_q;
  assign ser_out = q_q[W-1];

endmodule

// File: rtl/bscan_bist_sig.sv
module bscan_bist_sig
  import bscan_bist_pkg::*;
#(
  parameter int           W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011,
  parameter logic [W-1:0] SEED = 4'b1010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cell_op_e     op,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_q, q_d;
  logic [W-1:0] step;
  logic         en;

  assign step = {q_q[W-2:0], 1'b0} ^ (q_q[W-1] ? POLY : '0);
  assign en   = (op != OP_HOLD);

  always_comb begin
    unique case (op)
      OP_SEED:  q_d = SEED;
      OP_SHIFT: q_d = step ^ {{(W-1){1'b0}}, ser_in};
      OP_CAPT:  q_d = step ^ par_in;
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (en) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/bscan_bist_cells.sv
module bscan_bist_cells
  import bscan_bist_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cell_op_e     op,
  input  logic         ser_in,
  input  logic [W-1:0] cap_in,
  output logic [W-1:0] q,
  output logic         ser_out
);

  logic [W-1:0] q_q, q_d;
  logic [W-1:0] shift_src;
  logic         en;

  for (genvar i = 0; i < W; i++) begin : g_link
    if (i == 0) begin : g_head
      assign shift_src[i] = ser_in;
    end else begin : g_body
      assign shift_src[i] = q_q[i-1];
    end
  end

  assign en = (op != OP_HOLD);

  always_comb begin
    unique case (op)
      OP_SEED:  q_d = '0;
      OP_SHIFT: q_d = shift_src;
      OP_CAPT:  q_d = cap_in;
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (en) begin
      q_q <= q_d;
    end
  end

  assign q       = q_q;
  assign ser_out = q_q[W-1];

endmodule

// File: rtl/bscan_bist.sv
module bscan_bist
  import bscan_bist_pkg::*;
#(
  parameter int           N_IN      = 8,
  parameter int           N_OUT     = 8,
  parameter int           R         = 4,
  parameter int           S         = 4,
  parameter int           NUM_PAT   = 16,
  parameter logic [R-1:0] PRPG_POLY = 4'b1100,
  parameter logic [R-1:0] PRPG_SEED = 4'b0001,
  parameter logic [S-1:0] SIG_POLY  = 4'b0011,
  parameter logic [S-1:0] SIG_SEED  = 4'b1010,
  parameter logic [S-1:0] GOLDEN    = 4'b0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_IN-1:0]  sys_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] sys_out,
  output logic             test_active,
  output logic             done,
  output logic             pass
);

  localparam int L         = N_IN + N_OUT;
  localparam int SHIFT_LEN = L - S;
  localparam int MID_W     = L - R - S;
  localparam int IN_MID    = N_IN - R;

  logic             rst_q_n;
  bist_state_e      state;
  cell_op_e         op;
  logic [R-1:0]     prpg_q;
  logic             prpg_ser;
  logic [MID_W-1:0] mid_q;
  logic [MID_W-1:0] mid_cap;
  logic             mid_ser;
  logic [S-1:0]     sig_q;
  logic             sig_match;
  logic [N_IN-1:0]  in_cells;
  logic [N_OUT-1:0] out_cells;

  bscan_bist_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bscan_bist_ctrl #(
    .SHIFT_LEN (SHIFT_LEN),
    .NUM_PAT   (NUM_PAT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .start       (start),
    .sig_match   (sig_match),
    .state       (state),
    .op          (op),
    .test_active (test_active),
    .done        (done),
    .pass        (pass)
  );

  bscan_bist_prpg #(
    .W    (R),
    .POLY (PRPG_POLY),
    .SEED (PRPG_SEED)
  ) u_prpg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .op      (op),
    .q       (prpg_q),
    .ser_out (prpg_ser)
  );

  // Middle cells capture pin data (input side) and core data (output side).
  assign mid_cap = {core_out[N_OUT-S-1:0], sys_in[N_IN-1:R]};

  bscan_bist_cells #(
    .W (MID_W)
  ) u_cells (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .op      (op),
    .ser_in  (prpg_ser),
    .cap_in  (mid_cap),
    .q       (mid_q),
    .ser_out (mid_ser)
  );

  bscan_bist_sig #(
    .W    (S),
    .POLY (SIG_POLY),
    .SEED (SIG_SEED)
  ) u_sig (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .op     (op),
    .ser_in (mid_ser),
    .par_in (core_out[N_OUT-1:N_OUT-S]),
    .q      (sig_q)
  );

  assign sig_match = (sig_q == GOLDEN);

  assign in_cells  = {mid_q[IN_MID-1:0], prpg_q};
  assign out_cells = {sig_q, mid_q[MID_W-1:IN_MID]};

  // Transparent outside a run; cells drive both sides during a run.
  assign core_in = test_active ? in_cells  : sys_in;
  assign sys_out = test_active ? out_cells : core_out;

endmodule

// File: rtl/bscan_bist_chk.sv
module bscan_bist_chk
  import bscan_bist_pkg::*;
#(
  parameter int           R         = 4,
  parameter int           S         = 4,
  parameter logic [R-1:0] PRPG_SEED = 4'b0001,
  parameter logic [S-1:0] SIG_SEED  = 4'b1010
) (
  input logic        clk,
  input logic        rst_n,
  input bist_state_e state,
  input logic        start,
  input logic        test_active,
  input logic        done,
  input logic        pass,
  input logic [R-1:0] prpg_q,
  input logic [S-1:0] sig_q
);

  // R3: seed cycle loads both registers.
  assert_seed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEED) |=> (prpg_q == PRPG_SEED) && (sig_q == SIG_SEED));

  // R5: source holds through a capture cycle.
  assert_capt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPT) |=> $stable(prpg_q));

  // R6: a run in progress leaves only through the compare phase.
  assert_run_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && (state != ST_CMP) |=> (state != ST_IDLE));

  // R7: done rises together with the end of test mode.
  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(test_active));

  // R7: flags hold until a new start.
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7: pass is only meaningful with done.
  assert_pass_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R8: start during a run does not restart the seed phase.
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) && start |=> (state != ST_SEED));

  // R10: the source never reaches all zeros.
  assert_prpg_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prpg_q != '0);

endmodule

bind bscan_bist bscan_bist_chk #(
  .R         (R),
  .S         (S),
  .PRPG_SEED (PRPG_SEED),
  .SIG_SEED  (SIG_SEED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .state       (state),
  .start       (start),
  .test_active (test_active),
  .done        (done),
  .pass        (pass),
  .prpg_q      (prpg_q),
  .sig_q       (sig_q)
);

// File: tb/test_bscan_bist.sv
module test_bscan_bist;

  localparam int           N_IN    = 6;
  localparam int           N_OUT   = 5;
  localparam int           R       = 3;
  localparam int           S       = 3;
  localparam int           NUM_PAT = 4;
  localparam int           L       = N_IN + N_OUT;
  localparam logic [R-1:0] P_POLY  = 3'b110;
  localparam logic [R-1:0] P_SEED  = 3'b001;
  localparam logic [S-1:0] S_POLY  = 3'b011;
  localparam logic [S-1:0] S_SEED  = 3'b101;
  localparam logic [N_IN-1:0] SYS_TEST = 6'b101101;
  localparam int RUN_CYC = 2 + (NUM_PAT + 1) * (L - S) + NUM_PAT;

  // Bench core: combinational, with an optional injected fault.
  function automatic logic [N_OUT-1:0] core_fn(input logic [N_IN-1:0] x, input logic f);
    logic [N_OUT-1:0] y;
    y = (x[5:1] + x[4:0]) ^ {2'b00, x[5], x[0], x[2]};
    if (f && x[3]) y[2] = ~y[2];
    return y;
  endfunction

  function automatic logic [S-1:0] sig_step(input logic [S-1:0] m);
    return {m[S-2:0], 1'b0} ^ (m[S-1] ? S_POLY : '0);
  endfunction

  function automatic logic [L-1:0] m_shift(input logic [L-1:0] c);
    logic [L-1:0] n;
    n = c;
    n[R-1:0] = {c[R-2:0], ^(c[R-1:0] & P_POLY)};
    for (int i = R; i < L - S; i++) n[i] = c[i-1];
    n[L-1:L-S] = sig_step(c[L-1:L-S]) ^ {{(S-1){1'b0}}, c[L-S-1]};
    return n;
  endfunction

  function automatic logic [L-1:0] m_capt(input logic [L-1:0] c, input logic [N_IN-1:0] si,
                                          input logic f);
    logic [L-1:0]     n;
    logic [N_OUT-1:0] co;
    n  = c;
    co = core_fn(c[N_IN-1:0], f);
    n[N_IN-1:R]   = si[N_IN-1:R];
    n[L-S-1:N_IN] = co[N_OUT-S-1:0];
    n[L-1:L-S]    = sig_step(c[L-1:L-S]) ^ co[N_OUT-1:N_OUT-S];
    return n;
  endfunction

  function automatic logic [S-1:0] calc_sig(input logic f);
    logic [L-1:0] c;
    c = '0;
    c[R-1:0]   = P_SEED;
    c[L-1:L-S] = S_SEED;
    for (int p = 0; p < NUM_PAT; p++) begin
      for (int k = 0; k < L - S; k++) c = m_shift(c);
      c = m_capt(c, SYS_TEST, f);
    end
    for (int k = 0; k < L - S; k++) c = m_shift(c);
    return c[L-1:L-S];
  endfunction

  localparam logic [S-1:0] GOLD = calc_sig(1'b0);

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [N_IN-1:0]  sys_in;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] core_out;
  logic [N_OUT-1:0] sys_out;
  logic             test_active, done, pass;
  logic             fault;

  assign core_out = core_fn(core_in, fault);

  bscan_bist #(
    .N_IN (N_IN), .N_OUT (N_OUT), .R (R), .S (S), .NUM_PAT (NUM_PAT),
    .PRPG_POLY (P_POLY), .PRPG_SEED (P_SEED),
    .SIG_POLY (S_POLY), .SIG_SEED (S_SEED), .GOLDEN (GOLD)
  ) i_bscan_bist (
    .clk (clk), .rst_n (rst_n), .start (start), .sys_in (sys_in),
    .core_in (core_in), .core_out (core_out), .sys_out (sys_out),
    .test_active (test_active), .done (done), .pass (pass)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors;
  int miscompares;

  // Reference model state.
  logic [L-1:0] mc;
  int           mst;       // 0 idle, 1 seed, 2 shift, 3 capture, 4 compare
  int           mcnt, mpat;
  logic         mdone, mpass;
  string        mtag;      // requirement of the last model action
  int           act_cycles;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic st, input logic [N_IN-1:0] si);
    case (mst)
      0: if (st) begin mst = 1; mdone = 1'b0; mpass = 1'b0; mtag = "R2"; end
      1: begin
        mc = '0; mc[R-1:0] = P_SEED; mc[L-1:L-S] = S_SEED;
        mst = 2; mcnt = 0; mpat = 0; mtag = "R3";
      end
      2: begin
        mc = m_shift(mc); mcnt++; mtag = "R4";
        if (mcnt == L - S) begin
          mcnt = 0;
          mst  = (mpat == NUM_PAT) ? 4 : 3;
        end
      end
      3: begin mc = m_capt(mc, si, fault); mpat++; mst = 2; mtag = "R5"; end
      default: begin mdone = 1'b1; mpass = (mc[L-1:L-S] == GOLD); mst = 0; mtag = "R7"; end
    endcase
  endtask

  // One cycle: drive, compare the model with the ports, advance the model.
  task automatic tick(input logic st, input logic [N_IN-1:0] si);
    logic             t;
    logic [N_IN-1:0]  e_in;
    logic [N_OUT-1:0] e_out;
    string            tg;
    start  = st;
    sys_in = si;
    #1;
    t     = (mst != 0);
    e_in  = t ? mc[N_IN-1:0] : si;
    e_out = t ? mc[L-1:N_IN] : core_fn(si, fault);
    tg    = !t ? "R1" : (st ? "R8" : mtag);
    chk(test_active == t, (st && t) ? "R8" : "R6", "test_active", test_active, t);
    chk(core_in == e_in, tg, "core_in", core_in, e_in);
    chk(sys_out == e_out, tg, "sys_out", sys_out, e_out);
    chk(done == mdone && pass == mpass, "R7", "done/pass", {done, pass}, {mdone, mpass});
    if (test_active) begin
      act_cycles++;
      chk(core_in[R-1:0] != '0, "R10", "source nonzero", core_in[R-1:0], 1);
    end
    model_step(st, si);
    @(negedge clk);
  endtask

  task automatic run_test(input logic f);
    fault      = f;
    act_cycles = 0;
    tick(1'b1, SYS_TEST);
    for (int k = 0; k < 300; k++) begin
      if (mst == 0) break;
      tick((k % 13) == 6, SYS_TEST);   // R8: stray start pulses mid-run
    end
    chk(act_cycles == RUN_CYC, "R6", "run length", act_cycles, RUN_CYC);
    chk(done == 1'b1, "R7", "done after run", done, 1);
    chk(pass == (calc_sig(f) == GOLD), "R7", "pass verdict", pass, calc_sig(f) == GOLD);
  endtask

  // Watchdog.
  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors = 0; miscompares = 0;
    mc = '0; mc[R-1:0] = P_SEED;
    mst = 0; mcnt = 0; mpat = 0; mdone = 1'b0; mpass = 1'b0; mtag = "R1";
    fault = 1'b0; start = 1'b0; sys_in = 6'h15; rst_n = 1'b0;
    act_cycles = 0;

    // R9: reset state.
    repeat (3) @(negedge clk);
    #1;
    chk(done == 1'b0 && pass == 1'b0, "R9", "flags in reset", {done, pass}, 0);
    chk(test_active == 1'b0, "R9", "test_active in reset", test_active, 0);
    chk(core_in == sys_in, "R9", "core_in in reset", core_in, sys_in);
    chk(sys_out == core_fn(sys_in, 1'b0), "R9", "sys_out in reset", sys_out, core_fn(sys_in, 1'b0));

    // R9: start over the first two edges after release is ignored.
    @(negedge clk);
    rst_n = 1'b1;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(test_active == 1'b0, "R9", "start during reset release", test_active, 0);
    @(negedge clk);

    // R1: transparency under several pin patterns.
    tick(1'b0, 6'h00);
    tick(1'b0, 6'h3f);
    tick(1'b0, 6'h2a);
    tick(1'b0, 6'h19);

    // Fault-free run, then hold the flags (R7).
    run_test(1'b0);
    tick(1'b0, 6'h07);
    tick(1'b0, 6'h31);
    chk(done == 1'b1 && pass == 1'b1, "R7", "flags held", {done, pass}, 2'b11);

    // Faulty run: start clears flags, verdict follows the model.
    run_test(1'b1);
    tick(1'b0, 6'h0c);
    fault = 1'b0;
    tick(1'b0, 6'h2d);

    // A second clean run must pass again.
    run_test(1'b0);
    tick(1'b0, 6'h11);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule